// File: doc/BRIEF.md
# I/O Port Permission Checker

This block decides whether a port access issued in protected mode may proceed. A requester presents the current privilege level, the I/O privilege level, a protected-mode flag, a 16-bit port number, an access width code, the offset of the permission bitmap inside the task segment and that segment's limit, and pulses `start`. If the privilege levels or real mode already grant the access, the answer comes back on the next cycle and memory is never touched. In every other case the block first checks that the bitmap bytes it would need lie inside the segment. It then fetches them over a byte-wide read port with one cycle of latency and inspects the permission bits that the access covers.

The answer is a one-cycle `done` pulse carrying exactly one of `allow` or `fault`. A fault always stands for a general-protection fault whose error code is zero, so no code is carried on a port. The block does not perform the port cycle, load task state or deliver the exception.

Top module: `io_perm_check`

## Requirements
- R1: When `prot_mode` is 1 and `cpl` is numerically less than or equal to `iopl`, `done` and `allow` are high in the first cycle after the `start` edge, and `mem_req` stays low.
- R2: When `prot_mode` is 0, the access is allowed in the first cycle after the `start` edge regardless of the privilege levels, and `mem_req` stays low.
- R3: Port n is governed by bit (n & 7) of the bitmap byte at address `bmp_base + (n >> 3)`. On the checked path, `mem_req` is high with that address in cycle 1 after `start` and with that address plus one in cycle 2. Read data is expected one cycle after each request.
- R4: `acc_size` 2'b00 covers 1 bit, 2'b01 covers 2 bits, and 2'b10 or 2'b11 cover 4 bits. The covered bits are consecutive, starting at the port's bit, and may run from bit 7 of the first byte into the second byte.
- R5: On the checked path, `done` rises in cycle 4 after `start`. It carries `fault` if any covered bit is 1 and `allow` if all covered bits are 0.
- R6: If `bmp_base + (port >> 3) + 1` is greater than `seg_limit`, the result is a fault in cycle 1 with no memory read. If that sum equals `seg_limit`, the bitmap is read.
- R7: A `bmp_base` below 104 gives a fault in cycle 1 with no memory read.
- R8: `done` is a single-cycle pulse. While it is high, exactly one of `allow` and `fault` is high. While it is low, both are low.
- R9: After reset, `done`, `allow`, `fault` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a check; sampled while idle |
| prot_mode | input | 1 | 1 = protected mode, 0 = real mode |
| cpl | input | 2 | Current privilege level |
| iopl | input | 2 | I/O privilege level |
| port_addr | input | 16 | Port number of the access |
| acc_size | input | 2 | Width code: 0 byte, 1 word, 2/3 dword |
| bmp_base | input | 32 | Bitmap offset inside the task segment |
| seg_limit | input | 32 | Task segment limit |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | 32 | Byte read address |
| mem_rdata | input | 8 | Read data, valid one cycle after the request |
| done | output | 1 | Result pulse |
| allow | output | 1 | Access granted (with `done`) |
| fault | output | 1 | Protection fault, error code zero (with `done`) |

## Verification
The bench targets accesses whose covered bits cross from bit 7 of one byte into the next byte. A design that read only one byte, or built the mask without carrying into the second byte, would let such an access through or reject it wrongly. The bench places the segment limit exactly at `base + offset + 1` and one below it, which separates an off-by-one bounds check from a correct one. It also checks the equal-privilege case and real mode for the absence of any memory request, which catches a design that reads the bitmap when it does not need to. Finally, the 4-byte accesses and the reserved width code would expose a mask of the wrong width.

// File: rtl/iop_pkg.sv
package iop_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ0 = 3'd1,
        ST_READ1 = 3'd2,
        ST_EVAL  = 3'd3,
        ST_DONE  = 3'd4
    } iop_state_e;

    localparam logic [1:0] SZ_BYTE  = 2'b00;
    localparam logic [1:0] SZ_WORD  = 2'b01;
    localparam logic [1:0] SZ_DWORD = 2'b10;

endpackage

// File: rtl/iop_mask_gen.sv
module iop_mask_gen
    import iop_pkg::*;
#(
    parameter int MASK_W = 16
) (
    input  logic [2:0]        bit_pos,
    input  logic [1:0]        size_code,
    output logic [MASK_W-1:0] mask
);
    logic [3:0] run_bits;

    always_comb begin
        unique case (size_code)
            SZ_BYTE: run_bits = 4'b0001;
            SZ_WORD: run_bits = 4'b0011;
            default: run_bits = 4'b1111;
        endcase
        mask = {{(MASK_W-4){1'b0}}, run_bits} << bit_pos;
    end

endmodule

// File: rtl/iop_bound_chk.sv
module iop_bound_chk #(
    parameter int OFF_W    = 32,
    parameter int IDX_W    = 13,
    parameter int MIN_BASE = 104
) (
    input  logic [OFF_W-1:0] base,
    input  logic [IDX_W-1:0] byte_idx,
    input  logic [OFF_W-1:0] limit,
    output logic             out_of_range
);
    localparam int SUM_W = OFF_W + 1;

    logic [SUM_W-1:0] last_byte;

    always_comb begin
        last_byte    = {1'b0, base} + SUM_W'(byte_idx) + SUM_W'(1);
        out_of_range = (base < OFF_W'(MIN_BASE)) || (last_byte > {1'b0, limit});
    end

endmodule

// File: rtl/io_perm_check.sv
module io_perm_check
    import iop_pkg::*;
#(
    parameter int PORT_W   = 16,
    parameter int OFF_W    = 32,
    parameter int MIN_BASE = 104
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              prot_mode,
    input  logic [1:0]        cpl,
    input  logic [1:0]        iopl,
    input  logic [PORT_W-1:0] port_addr,
    input  logic [1:0]        acc_size,
    input  logic [OFF_W-1:0]  bmp_base,
    input  logic [OFF_W-1:0]  seg_limit,
    output logic              mem_req,
    output logic [OFF_W-1:0]  mem_addr,
    input  logic [7:0]        mem_rdata,
    output logic              done,
    output logic              allow,
    output logic              fault
);
    localparam int IDX_W  = PORT_W - 3;
    localparam int MASK_W = 16;

    typedef struct packed {
        iop_state_e        state;
        logic [OFF_W-1:0]  addr;
        logic [MASK_W-1:0] mask;
        logic [7:0]        lo_byte;
        logic              allow;
        logic              fault;
    } regs_t;

    regs_t r_q, r_d;

    logic [IDX_W-1:0]  byte_idx;
    logic [MASK_W-1:0] new_mask;
    logic              oob;
    logic              priv_ok;

    assign byte_idx = port_addr[PORT_W-1:3];
    assign priv_ok  = !prot_mode || (cpl <= iopl);

    iop_mask_gen #(.MASK_W(MASK_W)) u_mask (
        .bit_pos   (port_addr[2:0]),
        .size_code (acc_size),
        .mask      (new_mask)
    );

    iop_bound_chk #(.OFF_W(OFF_W), .IDX_W(IDX_W), .MIN_BASE(MIN_BASE)) u_bound (
        .base         (bmp_base),
        .byte_idx     (byte_idx),
        .limit        (seg_limit),
        .out_of_range (oob)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.addr = bmp_base + OFF_W'(byte_idx);
                    r_d.mask = new_mask;
                    if (priv_ok) begin
                        r_d.state = ST_DONE;
                        r_d.allow = 1'b1;
                    end else if (oob) begin
                        r_d.state = ST_DONE;
                        r_d.fault = 1'b1;
                    end else begin
                        r_d.state = ST_READ0;
                    end
                end
            end
            ST_READ0: r_d.state = ST_READ1;
            ST_READ1: begin
                r_d.lo_byte = mem_rdata;
                r_d.state   = ST_EVAL;
            end
            ST_EVAL: begin
                r_d.state = ST_DONE;
                if (({mem_rdata, r_q.lo_byte} & r_q.mask) != '0) r_d.fault = 1'b1;
                else                                           r_d.allow = 1'b1;
            end
            ST_DONE: begin
                r_d.state = ST_IDLE;
                r_d.allow = 1'b0;
                r_d.fault = 1'b0;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, addr: '0, mask: '0, lo_byte: '0,
                     allow: 1'b0, fault: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_req  = (r_q.state == ST_READ0) || (r_q.state == ST_READ1);
    assign mem_addr = (r_q.state == ST_READ1) ? r_q.addr + OFF_W'(1) : r_q.addr;
    assign done     = (r_q.state == ST_DONE);
    assign allow    = r_q.allow;
    assign fault    = r_q.fault;

    assert_fast_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE && start && priv_ok) |=> (done && allow && !mem_req));

    assert_pair_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $past(mem_req)) |-> (mem_addr == $past(mem_addr) + OFF_W'(1)));

    assert_early_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE && start && !priv_ok && oob) |=> (done && fault && !mem_req));

    assert_one_verdict_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (allow ^ fault));

    assert_quiet_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (!allow && !fault));

    assert_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_no_req_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);

endmodule

// File: tb/sim_io_perm_check.sv
`timescale 1ns/1ps
module sim_io_perm_check;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        prot_mode = 1'b1;
    logic [1:0]  cpl = 2'd3;
    logic [1:0]  iopl = 2'd1;
    logic [15:0] port_addr = '0;
    logic [1:0]  acc_size = '0;
    logic [31:0] bmp_base = 32'd104;
    logic [31:0] seg_limit = 32'd1500;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [7:0]  mem_rdata = '0;
    logic        done, allow, fault;

    logic [7:0]  mem [2048];
    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    io_perm_check u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .prot_mode(prot_mode),
        .cpl(cpl), .iopl(iopl), .port_addr(port_addr), .acc_size(acc_size),
        .bmp_base(bmp_base), .seg_limit(seg_limit), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .done(done),
        .allow(allow), .fault(fault)
    );

    always @(posedge clk) if (mem_req) mem_rdata <= mem[mem_addr[10:0]];

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic outs(string tag, logic e_req, logic [31:0] e_addr,
                        logic e_done, logic e_allow, logic e_fault);
        check(tag, "mem_req", {31'b0, mem_req}, {31'b0, e_req});
        if (e_req) check(tag, "mem_addr", mem_addr, e_addr);
        check(tag, "done", {31'b0, done}, {31'b0, e_done});
        check(tag, "allow", {31'b0, allow}, {31'b0, e_allow});
        check(tag, "fault", {31'b0, fault}, {31'b0, e_fault});
    endtask

    task automatic run(string tag, logic pm, logic [1:0] c, logic [1:0] io,
                       logic [15:0] p, logic [1:0] sz, int base, int lim);
        int nb;
        int a0;
        bit fast, oob, bad;
        @(negedge clk);
        prot_mode = pm; cpl = c; iopl = io; port_addr = p; acc_size = sz;
        bmp_base = base; seg_limit = lim; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        nb   = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        a0   = base + (p >> 3);
        fast = !pm || (c <= io);
        oob  = (base < 104) || (a0 + 1 > lim);
        bad  = 1'b0;
        for (int i = 0; i < nb; i++) begin
            int bitn;
            bitn = p + i;
            if (mem[(base + (bitn >> 3)) % 2048][bitn % 8]) bad = 1'b1;
        end
        if (fast) begin
            outs(tag, 1'b0, 0, 1'b1, 1'b1, 1'b0);
        end else if (oob) begin
            outs(tag, 1'b0, 0, 1'b1, 1'b0, 1'b1);
        end else begin
            outs(tag, 1'b1, a0, 1'b0, 1'b0, 1'b0);
            @(negedge clk); outs(tag, 1'b1, a0 + 1, 1'b0, 1'b0, 1'b0);
            @(negedge clk); outs(tag, 1'b0, 0, 1'b0, 1'b0, 1'b0);
            @(negedge clk); outs(tag, 1'b0, 0, 1'b1, !bad, bad);
        end
        @(negedge clk); outs("R8", 1'b0, 0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        for (int i = 0; i < 2048; i++) mem[i] = 8'h00;
        mem[104 + 8] = 8'h80;
        mem[104 + 9] = 8'h60;
        repeat (3) @(negedge clk);
        outs("R9", 1'b0, 0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        outs("R9", 1'b0, 0, 1'b0, 1'b0, 1'b0);

        run("R5", 1, 2'd3, 2'd1, 16'h0021, 2'd0, 104, 1500);
        run("R3", 1, 2'd3, 2'd1, 16'h0047, 2'd0, 104, 1500);
        run("R5", 1, 2'd3, 2'd1, 16'h004E, 2'd0, 104, 1500);
        run("R4", 1, 2'd3, 2'd1, 16'h004C, 2'd1, 104, 1500);
        run("R4", 1, 2'd3, 2'd1, 16'h0046, 2'd1, 104, 1500);
        run("R4", 1, 2'd3, 2'd1, 16'h0047, 2'd1, 104, 1500);
        run("R5", 1, 2'd3, 2'd1, 16'h0042, 2'd2, 104, 1500);
        run("R4", 1, 2'd3, 2'd1, 16'h004D, 2'd2, 104, 1500);
        run("R4", 1, 2'd3, 2'd1, 16'h003F, 2'd1, 104, 1500);
        run("R4", 1, 2'd3, 2'd1, 16'h0044, 2'd3, 104, 1500);
        run("R3", 1, 2'd3, 2'd0, 16'h03F8, 2'd0, 104, 1500);
        run("R1", 1, 2'd0, 2'd1, 16'h0047, 2'd0, 104, 1500);
        run("R1", 1, 2'd2, 2'd2, 16'h004E, 2'd2, 104, 1500);
        run("R2", 0, 2'd3, 2'd0, 16'h0047, 2'd0, 104, 1500);
        run("R6", 1, 2'd3, 2'd1, 16'h0040, 2'd0, 104, 113);
        run("R6", 1, 2'd3, 2'd1, 16'h0040, 2'd0, 104, 112);
        run("R6", 1, 2'd3, 2'd1, 16'hFFFF, 2'd2, 104, 1500);
        run("R7", 1, 2'd3, 2'd1, 16'h0021, 2'd0, 103, 1500);

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule